// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Reporting

This block takes one idle-high serial line and turns each character on it into a parallel word. It runs from a one-cycle enable pulse at sixteen times the bit rate. A falling edge is taken as a possible start bit and is checked again half a bit later. The data bits, the optional parity bit and the stop bits are each sampled in the middle of their bit period. The finished character is then copied from the shift register into a receive buffer.

The buffer reports whether it holds unread data. Three error flags sit beside it, for a buffer overwritten before it was read, a missing stop level and a parity mismatch, and a fourth flag is the OR of the three. A one-cycle receive interrupt marks every character that lands in an empty (or just-read) buffer. The line format is selected on static inputs: 7, 8 or 9 data bits, parity off, even or odd, and one or two stop bits. It is meant to be paired with a transmitter that uses the same format inputs.

Top module: `async_rx`

## Requirements
- R1: While `rx_en` is 0, the receiver ignores the line: no character is accepted and `rx_irq` stays 0. A reception that is in progress is abandoned when `rx_en` falls.
- R2: A low level that lasts less than half a bit period is discarded as noise. The receiver goes back to idle, `rx_irq` stays 0 and the buffer is unchanged.
- R3: Data bits are sampled mid-bit and taken least-significant bit first. `len_sel` 2'b00 gives 7 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 gives 9 bits. `rx_data` is right-aligned, with the unused upper bits 0.
- R4: `rx_irq` is a one-cycle pulse that comes one cycle after the character is complete. `buf_full` is 1 from that cycle on. `rx_data` changes only when a character completes.
- R5: If a character completes while `buf_full` is 1 and `rd_strobe` is 0, the new character still overwrites `rx_data` and `ovr_err` becomes 1. No `rx_irq` is raised for that character.
- R6: `frm_err` is set for a character when any of its configured stop-bit samples (one, or two when `two_stop` is 1) is low.
- R7: `par_sel[0]` enables parity and `par_sel[1]` selects odd (1) or even (0). With parity enabled, `par_err` is set when the number of ones across the data and parity bits is odd for even parity, or even for odd parity. With parity disabled, `par_err` is 0.
- R8: A one-cycle `rd_strobe` clears `buf_full` and `ovr_err`. `frm_err` and `par_err` keep their values until the next character replaces them.
- R9: `err_sum` is 1 exactly when at least one of `ovr_err`, `frm_err` or `par_err` is 1.
- R10: After a character ends, or after a low stop level, a new start bit is accepted only once the line has been seen high. A line held low therefore yields a single character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| tick16 | input | 1 | One-cycle pulse at 16x bit rate |
| line_in | input | 1 | Serial line, idle high, asynchronous |
| len_sel | input | 2 | Character length select |
| par_sel | input | 2 | Bit 0 parity enable, bit 1 odd parity |
| two_stop | input | 1 | 1 selects two stop bits |
| rd_strobe | input | 1 | Buffer read acknowledge |
| rx_data | output | 9 | Receive buffer, right-aligned |
| buf_full | output | 1 | Buffer holds unread data |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
A bit counter or sample phase that has drifted shows up on the next character. The value in `rx_data` comes out shifted or truncated, or `frm_err` is set on a clean frame, all within one character time. A wrong buffer-full state becomes visible at the first back-to-back character: either a spurious `ovr_err` with the interrupt missing, or a silent overwrite with the interrupt present. A lost re-arm condition shows as extra characters while the line is held low. The tests use distinct values for each character length and both parity senses, so that misplaced bits and inverted parity cannot hide each other.

// File: rtl/async_rx_pkg.sv
// Package: shared types and format decoding for the serial receiver.
// Assumes characters are at most 9 bits wide.
package async_rx_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
        logic              frm_bad;
    } rx_char_t;

    // Number of data bits for a length select code.
    function automatic logic [3:0] char_len(input logic [1:0] sel);
        case (sel)
            2'b00:   char_len = 4'd7;
            2'b01:   char_len = 4'd8;
            default: char_len = 4'd9;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Module: multi-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// Module: start detection, mid-bit sampling and character assembly.
// Assumes tick is a one-cycle pulse at OVS times the bit rate and that the
// format inputs stay static during a character. Emits a one-cycle done
// pulse carrying the assembled character and its error bits.
module rx_framer
    import async_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] len_sel,
    input  logic [1:0] par_sel,
    input  logic       two_stop,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_LAST  = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [3:0]        idx;
    logic [CHAR_W-1:0] shreg;
    logic              acc;
    logic              fbad;
    logic              armed;

    logic       sample_pt;
    logic [3:0] last_idx;
    logic       par_on;
    logic       stop_bad;

    // Decide whether this tick is the sampling point of the current bit.
    always_comb begin
        sample_pt = tick && (cnt == ((state == ST_START) ? MID_LAST : FULL_LAST));
        last_idx  = char_len(len_sel) - 4'd1;
        par_on    = par_sel[0];
        stop_bad  = fbad | ~line;
    end

    // Frame state machine with its bit counters and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            acc   <= 1'b0;
            fbad  <= 1'b0;
            armed <= 1'b0;
            done  <= 1'b0;
            chr   <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
                armed <= 1'b0;
            end else if (state == ST_IDLE) begin
                if (line) begin
                    armed <= 1'b1;
                end else if (armed) begin
                    state <= ST_START;
                    cnt   <= '0;
                    armed <= 1'b0;
                end
            end else if (tick) begin
                if (!sample_pt) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    case (state)
                        ST_START: begin
                            if (line) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_DATA;
                                idx   <= '0;
                                shreg <= '0;
                                acc   <= 1'b0;
                                fbad  <= 1'b0;
                            end
                        end
                        ST_DATA: begin
                            shreg[idx] <= line;
                            acc        <= acc ^ line;
                            idx        <= idx + 4'd1;
                            if (idx == last_idx) state <= par_on ? ST_PAR : ST_STOP1;
                        end
                        ST_PAR: begin
                            acc   <= acc ^ line;
                            state <= ST_STOP1;
                        end
                        ST_STOP1: begin
                            if (two_stop) begin
                                fbad  <= stop_bad;
                                state <= ST_STOP2;
                            end else begin
                                state       <= ST_IDLE;
                                done        <= 1'b1;
                                chr.data    <= shreg;
                                chr.frm_bad <= stop_bad;
                                chr.par_bad <= par_on && (par_sel[1] ? ~acc : acc);
                            end
                        end
                        default: begin
                            state       <= ST_IDLE;
                            done        <= 1'b1;
                            chr.data    <= shreg;
                            chr.frm_bad <= stop_bad;
                            chr.par_bad <= par_on && (par_sel[1] ? ~acc : acc);
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rx_buffer.sv
// Module: receive buffer with overrun, framing and parity flags and the
// receive interrupt pulse. Assumes load is a one-cycle pulse per character.
// A read in the same cycle as a load counts as emptying the buffer first.
module rx_buffer
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  rx_char_t          chr,
    input  logic              rd,
    output logic [CHAR_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              frm,
    output logic              par,
    output logic              irq
);
    // Capture completed characters and maintain the status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
            frm  <= 1'b0;
            par  <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                data <= chr.data;
                frm  <= chr.frm_bad;
                par  <= chr.par_bad;
                full <= 1'b1;
                if (full && !rd) begin
                    ovr <= 1'b1;
                end else begin
                    irq <= 1'b1;
                    if (rd) ovr <= 1'b0;
                end
            end else if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/async_rx.sv
// Module: top of the asynchronous serial receiver.
// Assumes tick16 is a one-cycle pulse at 16x the bit rate and that line_in
// is asynchronous to clk. Connects synchronizer, framer and buffer.
module async_rx
    import async_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick16,
    input  logic              line_in,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        par_sel,
    input  logic              two_stop,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              err_sum,
    output logic              rx_irq
);
    logic     line_s;
    logic     char_done;
    rx_char_t char_q;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (tick16),
        .line     (line_s),
        .len_sel  (len_sel),
        .par_sel  (par_sel),
        .two_stop (two_stop),
        .done     (char_done),
        .chr      (char_q)
    );

    rx_buffer u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (char_done),
        .chr   (char_q),
        .rd    (rd_strobe),
        .data  (rx_data),
        .full  (buf_full),
        .ovr   (ovr_err),
        .frm   (frm_err),
        .par   (par_err),
        .irq   (rx_irq)
    );

    // Combined error indication.
    assign err_sum = ovr_err | frm_err | par_err;
endmodule

// File: rtl/async_rx_chk.sv
// Module: property checker for async_rx, attached with bind below.
// Assumes characters complete far apart (many cycles between done pulses).
module async_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_strobe,
    input logic       char_done,
    input logic       rx_irq,
    input logic       buf_full,
    input logic       ovr_err,
    input logic [8:0] rx_data
);
    // R4: an interrupt always comes with a full buffer.
    a_r4_irq_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);

    // R4: an interrupt follows a completed character by one cycle.
    a_r4_irq_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(char_done));

    // R4: the buffer only changes when a character completes.
    a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !char_done |=> $stable(rx_data));

    // R5: an overrun character raises no interrupt.
    a_r5_overrun_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> !rx_irq);

    // R8: a read with no character arriving empties the buffer and clears overrun.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !char_done) |=> (!buf_full && !ovr_err));

    // R1: with reception disabled no interrupt follows.
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> ##2 !rx_irq);
endmodule

bind async_rx async_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rd_strobe (rd_strobe),
    .char_done (char_done),
    .rx_irq    (rx_irq),
    .buf_full  (buf_full),
    .ovr_err   (ovr_err),
    .rx_data   (rx_data)
);

// File: tb/async_rx_tb.sv
// Directed bench for async_rx: one task per scenario, each checks itself.
module async_rx_tb;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       tick16 = 1'b0;
    logic       line_in = 1'b1;
    logic [1:0] len_sel = 2'b01;
    logic [1:0] par_sel = 2'b00;
    logic       two_stop = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       buf_full, ovr_err, frm_err, par_err, err_sum, rx_irq;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    int cyc = 0;
    int tdiv = 0;

    async_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16),
        .line_in(line_in), .len_sel(len_sel), .par_sel(par_sel),
        .two_stop(two_stop), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .buf_full(buf_full), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .err_sum(err_sum), .rx_irq(rx_irq)
    );

    always #2.5 clk = ~clk;

    // Tick generator, interrupt counter and watchdog, all on the falling edge.
    always @(negedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV - 1);
        if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    function automatic logic par_bit(input logic [8:0] d, input int n, input logic odd);
        logic p = odd;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    // Send one frame: start, n data bits, optional parity, stop bits, idle.
    task automatic send(input logic [8:0] d, input int n, input logic pen,
                        input logic pv, input int nstop, input logic s1, input logic s2);
        line_in = 1'b0; hold(BIT_CLK);
        for (int i = 0; i < n; i++) begin line_in = d[i]; hold(BIT_CLK); end
        if (pen) begin line_in = pv; hold(BIT_CLK); end
        line_in = s1; hold(BIT_CLK);
        if (nstop == 2) begin line_in = s2; hold(BIT_CLK); end
        line_in = 1'b1; hold(BIT_CLK + 16);
    endtask

    task automatic t_reset();
        chk("R4 reset full", buf_full, 0);
        chk("R9 reset sum", {ovr_err, frm_err, par_err, err_sum}, 0);
        chk("R4 reset data", rx_data, 0);
    endtask

    task automatic t_8bit();
        int c0 = irq_cnt;
        len_sel = 2'b01; par_sel = 2'b00; two_stop = 1'b0;
        send(9'h0A5, 8, 0, 0, 1, 1, 1);
        chk("R3 8-bit data", rx_data, 9'h0A5);
        chk("R4 irq once", irq_cnt - c0, 1);
        chk("R4 full", buf_full, 1);
        chk("R9 clean sum", err_sum, 0);
        do_read();
        chk("R8 read empties", buf_full, 0);
    endtask

    task automatic t_7bit();
        len_sel = 2'b00;
        send(9'h1D3, 7, 0, 0, 1, 1, 1);
        chk("R3 7-bit data", rx_data, 9'h053);
        do_read();
    endtask

    task automatic t_9bit_even();
        len_sel = 2'b10; par_sel = 2'b01;
        send(9'h1C6, 9, 1, par_bit(9'h1C6, 9, 0), 1, 1, 1);
        chk("R3 9-bit data", rx_data, 9'h1C6);
        chk("R7 even ok", par_err, 0);
        send(9'h0F1, 9, 1, ~par_bit(9'h0F1, 9, 0), 1, 1, 1);
        chk("R7 even bad", par_err, 1);
        do_read();
    endtask

    task automatic t_odd();
        len_sel = 2'b01; par_sel = 2'b11;
        send(9'h03C, 8, 1, par_bit(9'h03C, 8, 1), 1, 1, 1);
        chk("R7 odd ok", par_err, 0);
        send(9'h03C, 8, 1, ~par_bit(9'h03C, 8, 1), 1, 1, 1);
        chk("R7 odd bad", par_err, 1);
        chk("R9 sum on parity", err_sum, 1);
        do_read();
        chk("R8 parity kept after read", par_err, 1);
        par_sel = 2'b00;
    endtask

    task automatic t_frame();
        len_sel = 2'b01; two_stop = 1'b0;
        send(9'h05A, 8, 0, 0, 1, 0, 1);
        chk("R6 one stop low", frm_err, 1);
        chk("R9 sum on framing", err_sum, 1);
        do_read();
        send(9'h0C3, 8, 0, 0, 1, 1, 1);
        chk("R8 framing replaced", frm_err, 0);
        do_read();
        two_stop = 1'b1;
        send(9'h0C3, 8, 0, 0, 2, 1, 0);
        chk("R6 second stop low", frm_err, 1);
        send(9'h081, 8, 0, 0, 2, 1, 1);
        chk("R6 two stops ok", frm_err, 0);
        do_read();
        two_stop = 1'b0;
    endtask

    task automatic t_overrun();
        int c0 = irq_cnt;
        send(9'h011, 8, 0, 0, 1, 1, 1);
        send(9'h022, 8, 0, 0, 1, 1, 1);
        chk("R5 overwrite", rx_data, 9'h022);
        chk("R5 ovr flag", ovr_err, 1);
        chk("R5 single irq", irq_cnt - c0, 1);
        chk("R9 sum on overrun", err_sum, 1);
        do_read();
        chk("R8 ovr cleared", {buf_full, ovr_err, err_sum}, 0);
    endtask

    task automatic t_glitch();
        int c0 = irq_cnt;
        line_in = 1'b0; hold(3 * TICK_DIV);
        line_in = 1'b1; hold(2 * BIT_CLK);
        chk("R2 glitch no irq", irq_cnt - c0, 0);
        chk("R2 glitch buffer", buf_full, 0);
    endtask

    task automatic t_disabled();
        int c0 = irq_cnt;
        rx_en = 1'b0;
        send(9'h077, 8, 0, 0, 1, 1, 1);
        chk("R1 disabled no irq", irq_cnt - c0, 0);
        chk("R1 disabled data", rx_data, 9'h022);
        rx_en = 1'b1; hold(8);
    endtask

    task automatic t_break();
        int c0 = irq_cnt;
        line_in = 1'b0; hold(20 * BIT_CLK);
        line_in = 1'b1; hold(BIT_CLK);
        chk("R10 one char on break", irq_cnt - c0, 1);
        chk("R10 break data", rx_data, 9'h000);
        do_read();
        send(9'h0E7, 8, 0, 0, 1, 1, 1);
        chk("R10 rearm data", rx_data, 9'h0E7);
        chk("R10 rearm frame", frm_err, 0);
        do_read();
    endtask

    initial begin
        hold(4);
        rst_n = 1'b1;
        hold(2);
        t_reset();
        rx_en = 1'b1;
        hold(4);
        t_8bit();
        t_7bit();
        t_9bit_even();
        t_odd();
        t_frame();
        t_overrun();
        t_glitch();
        t_disabled();
        t_break();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule